// File: doc/BRIEF.md
# Single-Spike Window Temporal Encoder

This block converts one grayscale image into a single-spike temporal code. Each pixel is first reduced to one bit by comparing it with a threshold. A square window of side WIN then moves over the image with a stride of STRIDE pixels in both directions. Each window position is one input neuron. The number of zero-valued bits inside that window gives the time step on which that neuron fires its only spike of the frame.

A `start` pulse opens a frame. The image then arrives as a raster-ordered pixel stream, row by row, with each row scanned left to right. Pixels are qualified by `pix_valid`, and gaps are allowed. Every accepted pixel updates the zero counts of all windows that contain it, so no frame store is needed. After the last pixel has been accepted, the block runs a firing phase of R+1 steps, one clock cycle each, numbered 0 to R, where R = WIN*WIN. On each step, bit m of `spikes` is high only for the neurons whose count equals that step number. `frame_done` pulses once when the firing phase ends.

With the default parameters (a 28x28 image, a 3x3 window and stride 2) there are 13x13 = 169 neurons. Each zero count lies in the range 0 to 9.

Top module: `spike_window_encoder`

## Requirements
- R1: During and after reset, `spikes` is all zero and `frame_done` is 0, and the block waits for `start`.
- R2: A pixel binarizes to 1 when `pix_data >= threshold` and to 0 otherwise. A pixel equal to the threshold is therefore a 1.
- R3: The neuron at window row i and window column j has index m = i*NPOS + j, where NPOS = ceil((IMG_W-WIN+1)/STRIDE). It covers image rows i*STRIDE to i*STRIDE+WIN-1 and image columns j*STRIDE to j*STRIDE+WIN-1. Its delay is the number of 0 bits in that window, and any window position outside the image counts as a 0.
- R4: The firing phase begins in the cycle after the last pixel (row IMG_W-1, column IMG_W-1) is accepted. The step number equals the number of cycles since that cycle, from 0 up to R.
- R5: `spikes[m]` is high in exactly the one firing step that equals neuron m's delay, and it is low in every other cycle of the frame.
- R6: A window that holds only 0 bits has delay R and fires on the last step, step R.
- R7: `frame_done` is high for exactly one cycle, the cycle after step R, and `spikes` is zero in that cycle.
- R8: During loading, a pixel is taken only in a cycle with `pix_valid` high. Cycles with `pix_valid` low leave the counts and the raster position unchanged.
- R9: `start` has no effect while a frame is loading or firing. Pixels presented while the block is idle or firing have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new frame when idle |
| pix_valid | input | 1 | Qualifies `pix_data` |
| pix_data | input | PIX_W | Grayscale pixel, raster order |
| threshold | input | PIX_W | Binarization threshold |
| spikes | output | M | One spike bit per neuron, index i*NPOS+j |
| frame_done | output | 1 | One-cycle pulse after the last firing step |

## Verification
The last pixel is taken on a clock edge E. Step 0 of the firing phase is visible in the cycle after E, and step s is visible s cycles later. `frame_done` is visible in the cycle after step R, which is R+1 cycles after step 0. The bench drives inputs and samples outputs on the falling edge. After the falling edge that follows the last pixel, it compares the whole spike vector once per cycle against a vector computed from its own window counts. It then expects the done pulse on the next falling edge and expects it to be gone on the one after.

// File: rtl/swe_pkg.sv
// Shared definitions for the single-spike window encoder.
// Assumes nothing beyond integer parameters.
package swe_pkg;

    // Frame phases of the encoder
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_FIRE = 2'd2
    } phase_t;

    // Integer ceiling division for positive operands
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/swe_ctrl.sv
// Frame sequencer: tracks the raster position of incoming pixels,
// then runs the firing step counter and emits the done pulse.
// Assumes pixels arrive in raster order, IMG_W per row.
module swe_ctrl #(
    parameter int IMG_W  = 28,
    parameter int STEPS  = 9,
    parameter int RW     = 5,
    parameter int SW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pix_valid,
    output logic          clear,
    output logic          accept,
    output logic [RW-1:0] row,
    output logic [RW-1:0] col,
    output logic          firing,
    output logic [SW-1:0] step,
    output logic          done
);
    import swe_pkg::*;

    phase_t phase;
    logic   last_pix;

    // Strobes derived from the current phase
    always_comb begin
        clear    = (phase == PH_IDLE) && start;
        accept   = (phase == PH_LOAD) && pix_valid;
        firing   = (phase == PH_FIRE);
        last_pix = (int'(row) == IMG_W - 1) && (int'(col) == IMG_W - 1);
    end

    // Phase, raster position, step counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            row   <= '0;
            col   <= '0;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOAD;
                        row   <= '0;
                        col   <= '0;
                    end
                end
                PH_LOAD: begin
                    if (pix_valid) begin
                        if (last_pix) begin
                            phase <= PH_FIRE;
                            step  <= '0;
                        end else if (int'(col) == IMG_W - 1) begin
                            col <= '0;
                            row <= row + 1'b1;
                        end else begin
                            col <= col + 1'b1;
                        end
                    end
                end
                PH_FIRE: begin
                    if (int'(step) == STEPS) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        firing |-> (int'(step) <= STEPS)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        firing && (int'(step) == STEPS) |=> done && !firing); // R7
    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD) && !pix_valid |=> $stable(row) && $stable(col)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        firing && start && (int'(step) != STEPS) |=> firing); // R9

endmodule

// File: rtl/swe_zero_bank.sv
// Bank of per-neuron zero counters. Every accepted pixel bit that is 0
// increments each window covering its position. Window cells outside
// the image are preloaded as zeros on clear.
// Assumes row/col give the position of the accepted pixel.
module swe_zero_bank #(
    parameter int IMG_W  = 28,
    parameter int WIN    = 3,
    parameter int STRIDE = 2,
    parameter int NPOS   = 13,
    parameter int RW     = 5,
    parameter int DW     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       accept,
    input  logic                       pix_bit,
    input  logic [RW-1:0]              row,
    input  logic [RW-1:0]              col,
    output logic [NPOS*NPOS-1:0][DW-1:0] delays
);
    localparam int AREA = WIN * WIN;

    for (genvar gi = 0; gi < NPOS; gi++) begin : g_row
        for (genvar gj = 0; gj < NPOS; gj++) begin : g_col
            localparam int R0   = gi * STRIDE;
            localparam int C0   = gj * STRIDE;
            localparam int RIN  = (R0 + WIN > IMG_W) ? (IMG_W - R0) : WIN;
            localparam int CIN  = (C0 + WIN > IMG_W) ? (IMG_W - C0) : WIN;
            localparam int PAD  = AREA - RIN * CIN;
            localparam int IDX  = gi * NPOS + gj;

            logic hit;

            // Does the accepted pixel fall inside this window
            always_comb begin
                hit = (int'(row) >= R0) && (int'(row) < R0 + WIN) &&
                      (int'(col) >= C0) && (int'(col) < C0 + WIN);
            end

            // Zero counter for this neuron
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    delays[IDX] <= '0;
                end else if (clear) begin
                    delays[IDX] <= DW'(PAD);
                end else if (accept && hit && !pix_bit) begin
                    delays[IDX] <= delays[IDX] + 1'b1;
                end
            end

            AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                int'(delays[IDX]) <= AREA); // R3
        end
    end

endmodule

// File: rtl/swe_fire.sv
// Spike comparator: during the firing phase a neuron's bit is high
// only while the step counter equals its stored delay.
// Assumes step and delays share one width.
module swe_fire #(
    parameter int M  = 169,
    parameter int DW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                firing,
    input  logic [DW-1:0]       step,
    input  logic [M-1:0][DW-1:0] delays,
    output logic [M-1:0]        spikes
);
    for (genvar gm = 0; gm < M; gm++) begin : g_nrn
        // Match of the running step against this neuron's delay
        always_comb begin
            spikes[gm] = firing && (step == delays[gm]);
        end

        AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            spikes[gm] |=> !spikes[gm]); // R5
    end

endmodule

// File: rtl/spike_window_encoder.sv
// Top of the single-spike window encoder: binarizes the pixel stream,
// accumulates zero counts per strided window, then fires one spike per
// neuron at the step equal to its count, followed by a done pulse.
// Assumes a raster pixel stream of IMG_W x IMG_W after each start.
module spike_window_encoder #(
    parameter int IMG_W  = 28,
    parameter int WIN    = 3,
    parameter int STRIDE = 2,
    parameter int PIX_W  = 8,
    localparam int NPOS  = swe_pkg::ceil_div(IMG_W - WIN + 1, STRIDE),
    localparam int M     = NPOS * NPOS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [PIX_W-1:0] threshold,
    output logic [M-1:0]     spikes,
    output logic             frame_done
);
    localparam int STEPS = WIN * WIN;
    localparam int DW    = $clog2(STEPS + 1);
    localparam int RW    = $clog2(IMG_W);

    logic                clear;
    logic                accept;
    logic                firing;
    logic                pix_bit;
    logic [RW-1:0]       row;
    logic [RW-1:0]       col;
    logic [DW-1:0]       step;
    logic [M-1:0][DW-1:0] delays;

    // Threshold binarization of the incoming pixel
    always_comb begin
        pix_bit = (pix_data >= threshold);
    end

    swe_ctrl #(
        .IMG_W (IMG_W),
        .STEPS (STEPS),
        .RW    (RW),
        .SW    (DW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pix_valid (pix_valid),
        .clear     (clear),
        .accept    (accept),
        .row       (row),
        .col       (col),
        .firing    (firing),
        .step      (step),
        .done      (frame_done)
    );

    swe_zero_bank #(
        .IMG_W  (IMG_W),
        .WIN    (WIN),
        .STRIDE (STRIDE),
        .NPOS   (NPOS),
        .RW     (RW),
        .DW     (DW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .accept  (accept),
        .pix_bit (pix_bit),
        .row     (row),
        .col     (col),
        .delays  (delays)
    );

    swe_fire #(
        .M  (M),
        .DW (DW)
    ) u_fire (
        .clk    (clk),
        .rst_n  (rst_n),
        .firing (firing),
        .step   (step),
        .delays (delays),
        .spikes (spikes)
    );

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (spikes == '0)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !firing |-> (spikes == '0)); // R1

endmodule

// File: tb/spike_window_encoder_test.sv
// Self-checking bench for the single-spike window encoder.
module spike_window_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int IMG_W  = 28;
    localparam int WIN    = 3;
    localparam int STRIDE = 2;
    localparam int NPOS   = (IMG_W - WIN + 1 + STRIDE - 1) / STRIDE;
    localparam int M      = NPOS * NPOS;
    localparam int STEPS  = WIN * WIN;
    localparam int NVEC   = 7;
    // {pattern kind, threshold}
    localparam int VEC [NVEC][2] = '{
        '{0, 128}, '{1, 128}, '{2, 128}, '{3, 100},
        '{4, 120}, '{5, 77},  '{6, 78}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         pix_valid = 1'b0;
    logic [7:0]   pix_data = '0;
    logic [7:0]   threshold = '0;
    logic [M-1:0] spikes;
    logic         frame_done;

    int checks = 0;
    int errors = 0;
    int exp_delay [M];

    spike_window_encoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
        .pix_data(pix_data), .threshold(threshold),
        .spikes(spikes), .frame_done(frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int pix_val(input int kind, input int r, input int c);
        case (kind)
            0: return 200;
            1: return 10;
            2: return (r * 7 + c * 13) % 256;
            3: return ((r + c) % 2 == 1) ? 200 : 0;
            4: return r * 9;
            default: return 77;
        endcase
    endfunction

    // R2, R3: expected delay per neuron from the window zero count
    task automatic build_expected(input int kind, input int thr);
        for (int i = 0; i < NPOS; i++)
            for (int j = 0; j < NPOS; j++) begin
                int z = 0;
                for (int dr = 0; dr < WIN; dr++)
                    for (int dc = 0; dc < WIN; dc++) begin
                        int r = i * STRIDE + dr;
                        int c = j * STRIDE + dc;
                        if (r >= IMG_W || c >= IMG_W) z++;
                        else if (pix_val(kind, r, c) < thr) z++;
                    end
                exp_delay[i * NPOS + j] = z;
            end
    endtask

    task automatic check1(input string req, input logic [M-1:0] act,
                          input logic [M-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    // Run one frame; gaps inserts invalid cycles, mid_start pulses start while firing
    task automatic run_frame(input int kind, input int thr, input bit gaps,
                             input bit mid_start, input string req);
        logic [M-1:0] ev;
        build_expected(kind, thr);
        @(negedge clk);
        threshold = 8'(thr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int r = 0; r < IMG_W; r++)
            for (int c = 0; c < IMG_W; c++) begin
                if (gaps && ((r * IMG_W + c) % 5 == 2)) begin
                    pix_valid = 1'b0;
                    pix_data  = 8'd0;   // R8: would add zeros if taken
                    @(negedge clk);
                end
                pix_valid = 1'b1;
                pix_data  = 8'(pix_val(kind, r, c));
                if (r == 5 && c == 5) start = 1'b1;   // R9: start while loading
                @(negedge clk);
                start = 1'b0;
            end
        pix_valid = 1'b1;
        pix_data  = 8'd0;   // R9: pixels while firing are ignored
        for (int s = 0; s <= STEPS; s++) begin
            ev = '0;
            for (int m = 0; m < M; m++) ev[m] = (exp_delay[m] == s);
            check1($sformatf("%s step %0d (R4 R5)", req, s), spikes, ev);
            if (mid_start && s == 3) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        pix_valid = 1'b0;
        checks++;
        if (frame_done !== 1'b1 || spikes !== '0) begin
            errors++;
            $display("FAIL R7 done actual %b/%h expected 1/0", frame_done, spikes);
        end
        @(negedge clk);
        checks++;
        if (frame_done !== 1'b0) begin
            errors++;
            $display("FAIL R7 done width actual %b expected 0", frame_done);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check1("R1 reset spikes", spikes, '0);
        checks++;
        if (frame_done !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset done actual %b expected 0", frame_done);
        end
        rst_n = 1'b1;
        // R9: pixels while idle have no effect
        pix_valid = 1'b1;
        pix_data  = 8'd0;
        repeat (4) @(negedge clk);
        pix_valid = 1'b0;
        check1("R1 idle spikes", spikes, '0);
        for (int v = 0; v < NVEC; v++)
            run_frame(VEC[v][0], VEC[v][1], 1'b0, 1'b0,
                      $sformatf("R3 vec %0d", v));
        // R6: all-zero image fires every neuron on step STEPS
        run_frame(1, 200, 1'b0, 1'b0, "R6 all zero");
        // R8: valid gaps during loading
        run_frame(2, 128, 1'b1, 1'b0, "R8 gaps");
        // R9: start during firing
        run_frame(3, 100, 1'b0, 1'b1, "R9 start in fire");
        // R2: equality binarizes to one
        run_frame(5, 77, 1'b1, 1'b1, "R2 equal thr");
        repeat (3) @(negedge clk);
        check1("R9 quiet after frame", spikes, '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule